// File: doc/BRIEF.md
# Two-Stage PWM Clock Prescaler

This block produces the rate enable that advances the period counter of one pulse-width-modulator channel. Software writes one 8-bit control byte. A 2-bit coarse field either switches the channel off or divides the system clock by 1, 8 or 16. A 4-bit fine field then divides that rate again by any integer from 1 to 16. The result is a clock-enable pulse, one system clock wide, that the period counter samples. No derived clock is generated, so the whole block runs in one clock domain.

The same coarse field decides who owns a shared port pin. When the channel is on, `pin_to_pwm` hands the pin to the PWM output. When the channel is off, the pin goes back to the general-purpose port logic.

Each write restarts both dividers from zero, so the first tick after a write comes one full new period later. A small two-state controller sets whether the dividers run:

- `ST_OFF` moves to `ST_RUN` on a write with a non-zero coarse code (transition `T_ENABLE`).
- `ST_RUN` moves back to `ST_OFF` on a write with coarse code 00 (transition `T_DISABLE`).
- A write that leaves the state unchanged is transition `T_RELOAD`. It only clears the counters.

Top module: `pwm_clk_prescaler`

## Requirements
- R1: A write with `wr_en` high loads the control byte at the clock edge. Bits [3:0] hold the fine field and bits [5:4] hold the coarse field. `rd_data` shows the stored fields at those same positions from the next cycle on.
- R2: Bits [7:6] are unimplemented. They always read as 0, and any value written to them has no effect on ticks or on the pin select.
- R3: After reset the stored byte is 0x00, `tick` is low and `pin_to_pwm` is low.
- R4: The coarse field sets the first-stage ratio: 10 divides by 1, 11 divides by 8, 01 divides by 16, and 00 turns the channel off.
- R5: The fine field F divides the first-stage rate by F+1. With the channel on, ticks repeat every coarse ratio × (F+1) system clocks.
- R6: With coarse code 00, `tick` stays low for as long as the code is held, whatever the fine field is.
- R7: `pin_to_pwm` is high exactly when the stored coarse field is non-zero.
- R8: Any write restarts both dividers. Count the cycle right after the write edge as cycle 0. The first tick then appears in cycle N−1, where N is the new period, and no tick of the old setting appears after the write edge.
- R9: When the period N is greater than 1, `tick` is high for exactly one system clock per period.
- R10: Across all 48 enabled settings there are exactly 38 distinct tick periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System operating clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte to be written |
| rd_data | output | 8 | Stored control byte as read back |
| tick | output | 1 | One-clock rate enable for the PWM period counter |
| pin_to_pwm | output | 1 | High when the shared pin carries the PWM output |

## Verification
The coarse encoding is not monotonic. If codes 01 and 10 were swapped, or the codes were treated as a plain power of two, the sweep over every coarse and fine pair would measure the wrong period. If the fine field were applied as F instead of F+1, every period would come out short by one coarse ratio. Rewrites are placed partway through a running period: a design that keeps its old count would show a runt first tick. The bench also writes ones into bits 7:6, and any leakage from those bits would show up in the read-back or in the measured period. Finally, counting the distinct measured periods catches an encoding that produces the wrong set of rates even when each single period looks plausible.

// File: rtl/pwmpre_pkg.sv
package pwmpre_pkg;

    localparam int unsigned REG_W      = 8;
    localparam int unsigned FINE_W     = 4;
    localparam int unsigned COARSE_W   = 2;
    localparam int unsigned FINE_LSB   = 0;
    localparam int unsigned COARSE_LSB = 4;
    localparam int unsigned MAX_COARSE = 16;
    localparam int unsigned CNT_W      = $clog2(MAX_COARSE);

    typedef enum logic [COARSE_W-1:0] {
        CS_OFF   = 2'b00,
        CS_DIV16 = 2'b01,
        CS_DIV1  = 2'b10,
        CS_DIV8  = 2'b11
    } coarse_sel_e;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } run_state_e;

    function automatic int unsigned coarse_ratio(input coarse_sel_e sel);
        unique case (sel)
            CS_DIV16: return 16;
            CS_DIV1:  return 1;
            CS_DIV8:  return 8;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/pwmpre_ctrl_reg.sv
module pwmpre_ctrl_reg
    import pwmpre_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [REG_W-1:0]              wr_data,
    output coarse_sel_e                   coarse,
    output logic [FINE_W-1:0]             fine,
    output logic [REG_W-1:0]              rd_data
);

    localparam int unsigned COARSE_MSB = COARSE_LSB + COARSE_W - 1;
    localparam int unsigned FINE_MSB   = FINE_LSB + FINE_W - 1;

    coarse_sel_e       coarse_q;
    logic [FINE_W-1:0] fine_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coarse_q <= CS_OFF;
            fine_q   <= '0;
        end else if (wr_en) begin
            coarse_q <= coarse_sel_e'(wr_data[COARSE_MSB:COARSE_LSB]);
            fine_q   <= wr_data[FINE_MSB:FINE_LSB];
        end
    end

    always_comb begin
        rd_data                       = '0;
        rd_data[COARSE_MSB:COARSE_LSB] = coarse_q;
        rd_data[FINE_MSB:FINE_LSB]     = fine_q;
    end

    assign coarse = coarse_q;
    assign fine   = fine_q;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> (rd_data[5:0] == $past(wr_data[5:0]))); // R1

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:6] == 2'b00); // R2

endmodule

// File: rtl/pwmpre_seq.sv
module pwmpre_seq
    import pwmpre_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [COARSE_W-1:0] wr_coarse,
    output logic                run,
    output logic                clr
);

    run_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (wr_en && (wr_coarse != CS_OFF)) state_d = ST_RUN;  // T_ENABLE
            ST_RUN: if (wr_en && (wr_coarse == CS_OFF)) state_d = ST_OFF;  // T_DISABLE
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        run = 1'b0;
        clr = wr_en;
        unique case (state_q)
            ST_OFF: run = 1'b0;
            ST_RUN: run = 1'b1;
            default: run = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwmpre_coarse_div.sv
module pwmpre_coarse_div
    import pwmpre_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        run,
    input  coarse_sel_e sel,
    output logic        step
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    int unsigned      ratio;

    always_comb begin
        ratio = coarse_ratio(sel);
        limit = (ratio == 0) ? '0 : CNT_W'(ratio - 1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run) cnt_q <= '0;
        else if (cnt_q == limit)   cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end

    assign step = run && (cnt_q == limit);

    AST_COARSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == CS_OFF) |-> (cnt_q == '0)); // R6

    AST_COARSE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (cnt_q == '0)); // R8

endmodule

// File: rtl/pwmpre_fine_div.sv
module pwmpre_fine_div
    import pwmpre_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              run,
    input  logic              step,
    input  logic [FINE_W-1:0] fine,
    output logic              tick
);

    logic [FINE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run) cnt_q <= '0;
        else if (step) begin
            if (cnt_q == fine) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = step && (cnt_q == fine);

    AST_FINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (cnt_q == '0)); // R8

    AST_FINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= fine)); // R5

endmodule

// File: rtl/pwm_clk_prescaler.sv
module pwm_clk_prescaler
    import pwmpre_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       tick,
    output logic       pin_to_pwm
);

    coarse_sel_e       coarse;
    logic [FINE_W-1:0] fine;
    logic              run;
    logic              clr;
    logic              step;

    pwmpre_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .coarse  (coarse),
        .fine    (fine),
        .rd_data (rd_data)
    );

    pwmpre_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_coarse (wr_data[COARSE_LSB+COARSE_W-1:COARSE_LSB]),
        .run       (run),
        .clr       (clr)
    );

    pwmpre_coarse_div u_coarse (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .run   (run),
        .sel   (coarse),
        .step  (step)
    );

    pwmpre_fine_div u_fine (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .run   (run),
        .step  (step),
        .fine  (fine),
        .tick  (tick)
    );

    assign pin_to_pwm = run;

    AST_RUN_MATCHES_REG: assert property (@(posedge clk) disable iff (!rst_n)
        run == (coarse != CS_OFF)); // R7

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (coarse == CS_OFF) |-> !tick); // R6

    AST_NO_RUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data[5:0] != 6'h20)) |=> !tick); // R8

endmodule

// File: tb/test_pwm_clk_prescaler.sv
module test_pwm_clk_prescaler;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       tick;
    logic       pin_to_pwm;

    int checks = 0;
    int errors = 0;
    bit seen [0:256];

    always #4 clk = ~clk;

    pwm_clk_prescaler i_pwm_clk_prescaler (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .tick       (tick),
        .pin_to_pwm (pin_to_pwm)
    );

    function automatic int exp_ratio(input logic [1:0] c);
        case (c)
            2'b01:   return 16;
            2'b10:   return 1;
            2'b11:   return 8;
            default: return 0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write at one edge; return at the negedge of cycle 0 after it.
    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = $urandom;
    endtask

    // Observe 2N cycles from cycle 0; return first/second tick index and count.
    task automatic observe(input int n, output int first, output int second, output int cnt);
        first = -1; second = -1; cnt = 0;
        for (int i = 0; i < 2 * n; i++) begin
            if (tick) begin
                if (cnt == 0) first = i;
                else if (cnt == 1) second = i;
                cnt++;
            end
            @(negedge clk);
        end
    endtask

    task automatic run_setting(input logic [7:0] v);
        int n, f, s, c;
        logic [1:0] cs;
        cs = v[5:4];
        write_reg(v);
        check(rd_data == {2'b00, v[5:0]}, "R1/R2 readback", rd_data, {2'b00, v[5:0]});
        check(pin_to_pwm == (cs != 2'b00), "R7 pin select", pin_to_pwm, cs != 2'b00);
        if (cs == 2'b00) begin
            observe(150, f, s, c);
            check(c == 0, "R6 off no tick", c, 0);
        end else begin
            n = exp_ratio(cs) * (v[3:0] + 1);
            observe(n, f, s, c);
            check(f == n - 1, "R8 first tick", f, n - 1);
            check(s == 2 * n - 1, "R5 period", s - f, n);
            check(c == 2, "R9 one-wide tick", c, 2);
            if (s - f > 0 && s - f <= 256) seen[s - f] = 1'b1;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int distinct;
        int f, s, c, n;
        void'($urandom(32'd4711));
        for (int i = 0; i <= 256; i++) seen[i] = 1'b0;

        repeat (3) @(negedge clk);
        check(rd_data == 8'h00, "R3 reset reg", rd_data, 0);
        check(tick == 1'b0, "R3 reset tick", tick, 0);
        check(pin_to_pwm == 1'b0, "R3 reset pin", pin_to_pwm, 0);
        rst_n = 1'b1;
        observe(20, f, s, c);
        check(c == 0, "R3 idle after reset", c, 0);

        // Directed sweep of every coarse/fine pair, R4 and R5.
        for (int cs = 0; cs < 4; cs++)
            for (int fv = 0; fv < 16; fv++)
                run_setting({2'b00, 2'(cs), 4'(fv)});

        distinct = 0;
        for (int i = 0; i <= 256; i++) if (seen[i]) distinct++;
        check(distinct == 38, "R10 distinct periods", distinct, 38);

        // R4 spot checks of the non-monotonic coarse codes.
        run_setting(8'h10);
        run_setting(8'h20);
        run_setting(8'h30);

        // R2: ones in unused bits have no effect.
        run_setting(8'hF3);
        run_setting(8'hC0 | 8'h25);

        // R8: rewrite partway through a running period.
        for (int k = 0; k < 20; k++) begin
            logic [7:0] v;
            v = $urandom;
            if (v[5:4] == 2'b00) v[5:4] = 2'b11;
            write_reg(8'h37);
            repeat ($urandom_range(1, 100)) @(negedge clk);
            n = exp_ratio(v[5:4]) * (v[3:0] + 1);
            write_reg(v);
            observe(n, f, s, c);
            check(f == n - 1, "R8 restart first tick", f, n - 1);
            check(c == 2, "R9 restart tick count", c, 2);
        end

        // Random settings, including off codes, R6 and R7.
        for (int k = 0; k < 30; k++) run_setting(8'($urandom));

        // Turn off while running: R6.
        write_reg(8'h20);
        write_reg(8'h0F);
        observe(100, f, s, c);
        check(c == 0, "R6 off after run", c, 0);
        check(pin_to_pwm == 1'b0, "R7 pin released", pin_to_pwm, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule